// File: doc/BRIEF.md
# Set/Clear Serial Pair Detector

This block watches a one-bit serial stream and consumes one bit on every rising clock edge. Its output is a latch that the stream itself controls. A 0 followed by a 1 sets the output. A 0 followed by another 0 clears it. Any pair whose earlier bit is 1 leaves the output where it was.

The output is Mealy style. It is a combinational function of the bit now on the input and of two stored flip-flop values: the previous bit and the latched output level. A consumer therefore samples it in the same cycle as the bit that produced it. The 0 that completes a clearing pair is also stored as history, so it can begin the next setting pair.

A parameter selects how the state is held: either two encoded flip-flops or a four-bit one-hot register. Both give the same behaviour at the ports.

Top module: `spd_set_clear_detector`

## Requirements
- R1: `rst` is synchronous and active high. On the first bit after reset is released, `z` is 0 whether that bit is 0 or 1, because there is no previous bit to form a pair.
- R2: When the previous bit was 0 and the current bit is 1, `z` is 1 in the current cycle.
- R3: When the previous bit was 1, `z` in the current cycle equals `z` in the previous cycle. This covers the pairs "11" and "10".
- R4: When the previous bit was 0 and the current bit is also 0, `z` is 0 in the current cycle.
- R5: The second 0 of a clearing pair is also the first bit of the next pair. For the bits 0,0,1, `z` is 0 on the second 0 and 1 on the 1.
- R6: `z` follows `x` inside a cycle with no clock edge in between. After a previous bit of 0, changing `x` between 0 and 1 changes `z` in the same way.
- R7: When the bits 0,1,0,1,0,0,1,0,0 are applied from reset, `z` is 0,1,1,1,1,0,1,1,0.
- R8: `STATE_STYLE` = 0 (two encoded flip-flops) and `STATE_STYLE` = 1 (one-hot, exactly one of four bits set outside reset) give identical `z` for every input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is consumed on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial data bit |
| z | output | 1 | Latched pair-detect output, combinational in `x` |

## Verification
The assertions check on every cycle how each kind of pair relates to `z`. A 0-then-1 pair forces 1 and a 0-then-0 pair forces 0. After a previous 1, `z` must equal its own past value. On the first bit after reset `z` must be 0, and the one-hot variant must hold exactly one state bit. The bench scenarios cover what a per-cycle property cannot show:
- the full example sequence;
- long runs of one value;
- overlap across a clearing pair;
- a reset in the middle of a latched sequence;
- the same-cycle response of `z` to a change of `x` in the middle of a cycle;
- agreement of both state encodings with a reference model over long random streams.

// File: rtl/spd_pkg.sv
package spd_pkg;

   // Two pieces of history: the latched output level and the previous bit.
   typedef struct packed {
      logic latched;
      logic prev_one;
   } spd_state_t;

   localparam int SPD_STATE_W = $bits(spd_state_t);
   localparam int SPD_NUM_STATES = 1 << SPD_STATE_W;

   // Reset state: output cleared, and the previous bit treated as 1 so that
   // the first bit can never complete a setting or clearing pair.
   localparam spd_state_t SPD_RESET_STATE = '{latched: 1'b0, prev_one: 1'b1};

   localparam int SPD_STYLE_BINARY = 0;
   localparam int SPD_STYLE_ONEHOT = 1;

endpackage

// File: rtl/spd_step_logic.sv
module spd_step_logic
   import spd_pkg::*;
(
   input  spd_state_t cur,
   input  logic       x,
   output logic       z,
   output spd_state_t nxt
);

   // A previous 0 makes the current bit decide the output: a 1 sets, a 0 clears.
   // A previous 1 keeps the latched level.
   always_comb begin
      if (cur.prev_one) z = cur.latched;
      else              z = x;
      nxt.latched  = z;
      nxt.prev_one = x;
   end

endmodule

// File: rtl/spd_state_store.sv
module spd_state_store
   import spd_pkg::*;
#(
   parameter int STATE_STYLE = SPD_STYLE_BINARY
) (
   input  logic       clk,
   input  logic       rst,
   input  spd_state_t d,
   output spd_state_t q
);

   generate
      if (STATE_STYLE == SPD_STYLE_BINARY) begin : g_binary
         spd_state_t st;
         always_ff @(posedge clk) begin
            if (rst) st <= SPD_RESET_STATE;
            else     st <= d;
         end
         assign q = st;
      end else if (STATE_STYLE == SPD_STYLE_ONEHOT) begin : g_onehot
         logic [SPD_NUM_STATES-1:0] oh;
         logic [SPD_NUM_STATES-1:0] oh_d;
         always_comb begin
            oh_d = '0;
            oh_d[d] = 1'b1;
         end
         always_ff @(posedge clk) begin
            if (rst) oh <= SPD_NUM_STATES'(1) << SPD_RESET_STATE;
            else     oh <= oh_d;
         end
         always_comb begin
            q = SPD_RESET_STATE;
            for (int i = 0; i < SPD_NUM_STATES; i++) begin
               if (oh[i]) q = spd_state_t'(SPD_STATE_W'(i));
            end
         end
         // R8: exactly one state bit is set outside reset
         a_r8_onehot_valid: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ($countones(oh) == 1));
      end else begin : g_bad_style
         $error("spd_state_store: STATE_STYLE must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/spd_set_clear_detector.sv
module spd_set_clear_detector
   import spd_pkg::*;
#(
   parameter int STATE_STYLE = SPD_STYLE_BINARY
) (
   input  logic clk,
   input  logic rst,
   input  logic x,
   output logic z
);

   spd_state_t cur;
   spd_state_t nxt;

   spd_state_store #(.STATE_STYLE(STATE_STYLE)) u_store (
      .clk (clk),
      .rst (rst),
      .d   (nxt),
      .q   (cur)
   );

   spd_step_logic u_step (
      .cur (cur),
      .x   (x),
      .z   (z),
      .nxt (nxt)
   );

   // R1: the first bit after reset never drives z high
   a_r1_first_bit_low: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !z);

   // R2: a 0-then-1 pair sets z in the current cycle
   a_r2_pair_sets: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(x) && x) |-> z);

   // R4: a 0-then-0 pair clears z in the current cycle
   a_r4_pair_clears: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(x) && !x) |-> !z);

   // R3: a pair whose earlier bit is 1 keeps the previous z
   a_r3_hold_after_one: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x)) |-> (z == $past(z)));

endmodule

// File: tb/test_spd_set_clear_detector.sv
module test_spd_set_clear_detector;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic z_bin;
   logic z_oh;

   always #4 clk = ~clk;   // 125 MHz

   spd_set_clear_detector #(.STATE_STYLE(0)) i_spd_set_clear_detector (
      .clk(clk), .rst(rst), .x(x), .z(z_bin));

   spd_set_clear_detector #(.STATE_STYLE(1)) i_spd_set_clear_detector_oh (
      .clk(clk), .rst(rst), .x(x), .z(z_oh));

   typedef struct {
      bit    exp;
      string req;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    m_latched = 1'b0;
   bit    m_prev    = 1'b1;
   bit    m_fresh   = 1'b1;

   // Driver: applies one bit and pushes the value z must take in this cycle.
   task automatic step(input bit xi, input string req);
      item_t it;
      @(negedge clk);
      rst = 1'b0;
      x   = xi;
      it.exp = m_prev ? m_latched : xi;
      if (req != "")       it.req = req;
      else if (m_fresh)    it.req = "R1";
      else if (m_prev)     it.req = "R3";
      else if (xi)         it.req = "R2";
      else                 it.req = "R4";
      q.push_back(it);
      m_latched = it.exp;
      m_prev    = xi;
      m_fresh   = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      x   = 1'($urandom);
      m_latched = 1'b0;
      m_prev    = 1'b1;
      m_fresh   = 1'b1;
   endtask

   task automatic direct_check(input bit act, input bit exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: z=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Monitor: pops expected values and compares both variants before the edge.
   always begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (z_bin !== it.exp) begin
            errors++;
            $display("FAIL %s: z=%0b expected %0b at %0t", it.req, z_bin, it.exp, $time);
         end
         checks++;
         if (z_oh !== it.exp) begin
            errors++;
            $display("FAIL R8 (%s, one-hot): z=%0b expected %0b at %0t", it.req, z_oh, it.exp, $time);
         end
      end
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: expired, actual hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit seq[9] = '{0, 1, 0, 1, 0, 0, 1, 0, 0};
      repeat (3) @(negedge clk);

      // R7: example sequence from reset (first bit is also an R1 case)
      foreach (seq[i]) step(seq[i], (i == 0) ? "R1" : "R7");

      // R1: first bit 1 after reset must not set
      do_reset();
      step(1'b1, "R1");
      step(1'b1, "R3");

      // Long runs of one value
      for (int i = 0; i < 20; i++) step(1'b0, "");
      for (int i = 0; i < 20; i++) step(1'b1, "");
      step(1'b0, "");
      step(1'b1, "R2");
      for (int i = 0; i < 20; i++) step(1'b1, "R3");
      step(1'b0, "R3");
      step(1'b0, "R4");
      for (int i = 0; i < 10; i++) step(1'b0, "R4");

      // R5: the second 0 of a clearing pair starts a setting pair
      step(1'b1, "R5");
      step(1'b0, "R5");
      step(1'b0, "R5");
      step(1'b1, "R5");

      // R6: z follows x within one cycle after a previous 0
      step(1'b0, "");
      @(negedge clk);
      x = 1'b1;
      #1 direct_check(z_bin, 1'b1, "R6");
      x = 1'b0;
      #1 direct_check(z_bin, 1'b0, "R6");
      x = 1'b1;
      #1 direct_check(z_oh, 1'b1, "R6");
      x = 1'b0;
      #1 direct_check(z_oh, 1'b0, "R6");
      m_latched = 1'b0;
      m_prev    = 1'b0;

      // Reset in the middle of a latched sequence
      step(1'b1, "R2");
      step(1'b1, "R3");
      do_reset();
      step(1'b0, "R1");
      step(1'b0, "R4");

      // Random streams with occasional reset
      for (int i = 0; i < 1500; i++) begin
         if (($urandom % 200) == 0) do_reset();
         step(1'($urandom), "");
      end

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule